// File: doc/BRIEF.md
# Accumulator Processor Sequencer

This block is a small accumulator machine whose control unit walks every instruction through explicit register transfers. The program counter is copied into the memory address register. One read strobe returns the instruction word into the memory data register, and that word is then moved into the current-instruction register. The program counter advances by one during the same fetch. A decode state splits the instruction into an operation code and a 12-bit operand. An execute sequence then uses the arithmetic unit, the memory port or the program counter, and returns to fetch.

The core owns one synchronous memory port: an address bus, a read strobe, a write strobe, a write-data bus and a read-data bus. The memory answers a read on the clock edge that follows the strobe, so it can sit in block RAM. The accumulator value, a zero indication and a halted indication are brought out as registered status outputs.

Top module: `accseq_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the accumulator reads 0, halted, read strobe and write strobe are low, and the first read strobe after reset addresses word 0.
- R2: Each instruction fetch drives the program counter onto the address bus with a one-cycle read strobe. Fetches that are not redirected address consecutive words.
- R3: An instruction word carries its operation code in bits [15:12] and its operand address in bits [11:0].
- R4: Operation code 1 (load) sets the accumulator to the memory word at the operand address.
- R5: Operation code 2 (store) writes the accumulator to the operand address with the write strobe. The read strobe stays low during that write.
- R6: Operation code 3 (add) sets the accumulator to accumulator plus memory word, modulo 2^16.
- R7: Operation code 4 (subtract) sets the accumulator to accumulator minus memory word, modulo 2^16.
- R8: Operation code 5 (jump) makes the next fetch come from the operand address.
- R9: Operation code 0 (halt) raises halted and keeps it high until reset. No further read or write strobe occurs in that time, and the accumulator is held.
- R10: Operation codes 6 to 15 change neither the accumulator nor memory, and the next fetch is sequential.
- R11: acc_zero is high exactly when the accumulator is 0.
- R12: The time from one instruction-fetch read strobe to the next is 9 cycles after load, add or subtract, 7 after store, 6 after jump and 5 after an unused code. A data read strobe comes 5 cycles after its own fetch strobe.
- R13: The program counter wraps from 0xFFF to 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |
| acc_value | output | 16 | Accumulator contents |
| acc_zero | output | 1 | Accumulator equals zero |
| halted | output | 1 | Core stopped by a halt instruction |

## Verification
Arithmetic is driven across the 16-bit boundary in both directions. A datapath that dropped or sign-extended the carry would leave a wrong accumulator, and the zero indication would disagree with it. One program jumps to the last word of memory, where an unused code sits. It relies on the counter wrapping to word 0, which an earlier store has rewritten into a halt. A core that failed to wrap, skipped the jump or treated the unused code as a store would run off or stop with the wrong accumulator. Strobe-to-strobe distances are measured per instruction class, so an added or missing transfer state shows up as a shifted fetch. After a halt the port is watched for stray strobes.

// File: rtl/accseq_pkg.sv
package accseq_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd5;

  typedef enum logic [3:0] {
    S_FADDR,   // PC -> MAR
    S_FREAD,   // read strobe, PC + 1
    S_FCAPT,   // bus -> MDR
    S_FLOAD,   // MDR -> CIR
    S_DECODE,  // split CIR, choose path
    S_XADDR,   // operand -> MAR (ACC -> MDR for store)
    S_XREAD,   // operand read strobe
    S_XCAPT,   // bus -> MDR
    S_XALU,    // ALU result -> ACC
    S_XWRITE,  // write strobe
    S_XJUMP,   // operand -> PC
    S_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_opr;
    logic pc_inc;
    logic pc_jump;
    logic mdr_from_bus;
    logic mdr_from_acc;
    logic cir_load;
    logic acc_load;
  } dp_ctrl_t;

endpackage

// File: rtl/accseq_alu.sv
module accseq_alu
  import accseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/accseq_ctrl.sv
module accseq_ctrl
  import accseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output dp_ctrl_t         ctl,
  output alu_op_e          alu_op,
  output logic             rd_q,
  output logic             wr_q,
  output logic             halted_q
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FADDR:  state_d = S_FREAD;
      S_FREAD:  state_d = S_FCAPT;
      S_FCAPT:  state_d = S_FLOAD;
      S_FLOAD:  state_d = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OPC_HALT:                             state_d = S_HALT;
          OPC_LOAD, OPC_STORE, OPC_ADD, OPC_SUB: state_d = S_XADDR;
          OPC_JUMP:                             state_d = S_XJUMP;
          default:                              state_d = S_FADDR;
        endcase
      end
      S_XADDR:  state_d = (opcode == OPC_STORE) ? S_XWRITE : S_XREAD;
      S_XREAD:  state_d = S_XCAPT;
      S_XCAPT:  state_d = S_XALU;
      S_XALU:   state_d = S_FADDR;
      S_XWRITE: state_d = S_FADDR;
      S_XJUMP:  state_d = S_FADDR;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_FADDR;
    endcase
  end

  always_comb begin
    ctl              = '0;
    ctl.mar_from_pc  = (state_q == S_FADDR);
    ctl.pc_inc       = (state_q == S_FREAD);
    ctl.mdr_from_bus = (state_q == S_FCAPT) || (state_q == S_XCAPT);
    ctl.cir_load     = (state_q == S_FLOAD);
    ctl.mar_from_opr = (state_q == S_XADDR);
    ctl.mdr_from_acc = (state_q == S_XADDR) && (opcode == OPC_STORE);
    ctl.acc_load     = (state_q == S_XALU);
    ctl.pc_jump      = (state_q == S_XJUMP);
  end

  always_comb begin
    unique case (opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      default: alu_op = ALU_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_FADDR;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_q     <= (state_d == S_FREAD) || (state_d == S_XREAD);
      wr_q     <= (state_d == S_XWRITE);
      halted_q <= (state_d == S_HALT);
    end
  end

  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> !rd_q);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> (!rd_q && !wr_q));

endmodule

// File: rtl/accseq_datapath.sv
module accseq_datapath
  import accseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctrl_t          ctl,
  input  logic [DATA_W-1:0] alu_y,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] cir_q,
  output logic [DATA_W-1:0] acc_q,
  output logic              zero_q
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] operand;

  assign operand = cir_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (ctl.pc_jump) begin
      pc_q <= operand;
    end else if (ctl.pc_inc) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
    end else if (ctl.mar_from_pc) begin
      mar_q <= pc_q;
    end else if (ctl.mar_from_opr) begin
      mar_q <= operand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mdr_q <= '0;
    end else if (ctl.mdr_from_bus) begin
      mdr_q <= bus_rdata;
    end else if (ctl.mdr_from_acc) begin
      mdr_q <= acc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cir_q <= '0;
    end else if (ctl.cir_load) begin
      cir_q <= mdr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      zero_q <= 1'b1;
    end else if (ctl.acc_load) begin
      acc_q  <= alu_y;
      zero_q <= (alu_y == '0);
    end
  end

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q == (acc_q == '0));

endmodule

// File: rtl/accseq_core.sv
module accseq_core
  import accseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [DATA_W-OPC_W-1:0] mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic [DATA_W-1:0]       acc_value,
  output logic                    acc_zero,
  output logic                    halted
);

  localparam int ADDR_W = DATA_W - OPC_W;

  dp_ctrl_t          ctl;
  alu_op_e           alu_op;
  logic [DATA_W-1:0] cir;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] alu_y;

  accseq_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (cir[DATA_W-1 -: OPC_W]),
    .ctl      (ctl),
    .alu_op   (alu_op),
    .rd_q     (mem_rd),
    .wr_q     (mem_wr),
    .halted_q (halted)
  );

  accseq_alu #(.DATA_W(DATA_W)) i_alu (
    .a  (acc),
    .b  (mdr),
    .op (alu_op),
    .y  (alu_y)
  );

  accseq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .alu_y     (alu_y),
    .bus_rdata (mem_rdata),
    .mar_q     (mem_addr),
    .mdr_q     (mdr),
    .cir_q     (cir),
    .acc_q     (acc),
    .zero_q    (acc_zero)
  );

  assign mem_wdata = mdr;
  assign acc_value = acc;

  // R5
  store_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == acc_value));

endmodule

// File: tb/test_accseq_core.sv
module test_accseq_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int LOG_N      = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata, acc_value;
  logic        acc_zero, halted;

  logic        tb_we = 1'b0;
  logic [11:0] tb_waddr = '0;
  logic [15:0] tb_wdata = '0;

  logic [15:0] mem [MEM_WORDS];
  logic [11:0] rd_addr [LOG_N];
  int          rd_cyc [LOG_N];
  int          rd_n = 0;
  int          wr_n = 0;
  int          cyc  = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accseq_core i_accseq_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_value(acc_value),
    .acc_zero(acc_zero), .halted(halted)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_waddr] <= tb_wdata;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      rd_addr[rd_n % LOG_N] <= mem_addr;
      rd_cyc[rd_n % LOG_N]  <= cyc;
      rd_n <= rd_n + 1;
    end
    if (mem_wr) wr_n <= wr_n + 1;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int a = 0; a < MEM_WORDS; a++) begin
      @(negedge clk);
      tb_we = 1'b1; tb_waddr = 12'(a); tb_wdata = 16'h0000;
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic run_prog(input string req);
    int n;
    @(negedge clk);
    base = rd_n;
    rst = 1'b0;
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " halted"}, 32'(halted), 32'd1);
  endtask

  task automatic t_reset();
    clear_mem();
    chk("R1 acc in reset", 32'(acc_value), 32'h0);
    chk("R1 halted in reset", 32'(halted), 32'd0);
    chk("R1 strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    put(12'h000, ins(4'd0, 12'h000));
    @(negedge clk);
    base = rd_n;
    rst = 1'b0;
    chk("R1 rd low after reset", 32'(mem_rd), 32'd0);
    chk("R1 acc after reset", 32'(acc_value), 32'h0);
    @(negedge clk);
    chk("R1 first fetch strobe", 32'(mem_rd), 32'd1);
    chk("R1 first fetch addr", 32'(mem_addr), 32'h000);
  endtask

  task automatic t_load_store();
    clear_mem();
    put(12'h000, ins(4'd1, 12'h100));
    put(12'h001, ins(4'd2, 12'h101));
    put(12'h002, ins(4'd0, 12'h000));
    put(12'h100, 16'hBEEF);
    run_prog("R3");
    chk("R4 load acc", 32'(acc_value), 32'hBEEF);
    chk("R5 store mem", 32'(mem[12'h101]), 32'hBEEF);
    chk("R11 nonzero", 32'(acc_zero), 32'd0);
  endtask

  task automatic t_arith();
    clear_mem();
    put(12'h000, ins(4'd1, 12'h100));
    put(12'h001, ins(4'd3, 12'h101));
    put(12'h002, ins(4'd2, 12'h102));
    put(12'h003, ins(4'd4, 12'h103));
    put(12'h004, ins(4'd2, 12'h104));
    put(12'h005, ins(4'd0, 12'h000));
    put(12'h100, 16'hFFF0);
    put(12'h101, 16'h0015);
    put(12'h103, 16'h0005);
    put(12'h104, 16'h1234);
    run_prog("R6");
    chk("R6 add wraps", 32'(mem[12'h102]), 32'h0005);
    chk("R7 sub to zero", 32'(acc_value), 32'h0000);
    chk("R5 store zero", 32'(mem[12'h104]), 32'h0000);
    chk("R11 zero high", 32'(acc_zero), 32'd1);
    clear_mem();
    put(12'h000, ins(4'd1, 12'h100));
    put(12'h001, ins(4'd4, 12'h101));
    put(12'h002, ins(4'd0, 12'h000));
    put(12'h100, 16'h0003);
    put(12'h101, 16'h0005);
    run_prog("R7");
    chk("R7 sub borrow", 32'(acc_value), 32'hFFFE);
    chk("R11 zero low", 32'(acc_zero), 32'd0);
  endtask

  task automatic t_jump_wrap();
    logic [11:0] exp_a [7];
    exp_a = '{12'h000, 12'h020, 12'h021, 12'h200, 12'h022, 12'hFFF, 12'h000};
    clear_mem();
    put(12'h000, ins(4'd5, 12'h020));
    put(12'h020, ins(4'd2, 12'h000));
    put(12'h021, ins(4'd1, 12'h200));
    put(12'h022, ins(4'd5, 12'hFFF));
    put(12'h023, ins(4'd1, 12'h201));
    put(12'hFFF, 16'h7ABC);
    put(12'h200, 16'h0042);
    put(12'h201, 16'h0999);
    run_prog("R8");
    for (int i = 0; i < 7; i++)
      chk($sformatf("R8 R13 R2 read %0d addr", i), 32'(rd_addr[(base + i) % LOG_N]), 32'(exp_a[i]));
    chk("R13 read count", 32'(rd_n - base), 32'd7);
    chk("R10 acc kept", 32'(acc_value), 32'h0042);
    chk("R10 mem kept", 32'(mem[12'hFFF]), 32'h7ABC);
    chk("R5 store rewrote word0", 32'(mem[12'h000]), 32'h0000);
  endtask

  task automatic t_timing();
    int w0;
    clear_mem();
    put(12'h000, ins(4'd1, 12'h100));
    put(12'h001, ins(4'd2, 12'h101));
    put(12'h002, ins(4'd5, 12'h003));
    put(12'h003, ins(4'd9, 12'h123));
    put(12'h004, ins(4'd0, 12'h000));
    put(12'h100, 16'h0077);
    w0 = wr_n;
    run_prog("R12");
    chk("R12 data read delay", 32'(rd_cyc[(base+1)%LOG_N] - rd_cyc[base%LOG_N]), 32'd5);
    chk("R12 load span", 32'(rd_cyc[(base+2)%LOG_N] - rd_cyc[base%LOG_N]), 32'd9);
    chk("R12 store span", 32'(rd_cyc[(base+3)%LOG_N] - rd_cyc[(base+2)%LOG_N]), 32'd7);
    chk("R12 jump span", 32'(rd_cyc[(base+4)%LOG_N] - rd_cyc[(base+3)%LOG_N]), 32'd6);
    chk("R12 unused code span", 32'(rd_cyc[(base+5)%LOG_N] - rd_cyc[(base+4)%LOG_N]), 32'd5);
    chk("R5 one write", 32'(wr_n - w0), 32'd1);
    chk("R10 unused code no write", 32'(mem[12'h123]), 32'h0000);
  endtask

  task automatic t_halt();
    int r0, w0;
    clear_mem();
    put(12'h000, ins(4'd1, 12'h100));
    put(12'h001, ins(4'd0, 12'h000));
    put(12'h002, ins(4'd2, 12'h100));
    put(12'h100, 16'h5A5A);
    run_prog("R9");
    r0 = rd_n; w0 = wr_n;
    repeat (30) @(negedge clk);
    chk("R9 halted held", 32'(halted), 32'd1);
    chk("R9 no reads", 32'(rd_n - r0), 32'd0);
    chk("R9 no writes", 32'(wr_n - w0), 32'd0);
    chk("R9 acc held", 32'(acc_value), 32'h5A5A);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears halted", 32'(halted), 32'd0);
    chk("R1 reset clears acc", 32'(acc_value), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_load_store();
    t_arith();
    t_jump_wrap();
    t_timing();
    t_halt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule